// File: doc/BRIEF.md
# Wraparound Bit-Range Mask Generator

This block turns a pair of 6-bit bit indices into a 64-bit mask. The mask holds a single contiguous run of ones that starts at the first index and ends at the second. Bits are numbered from the most significant end: index 0 is the leftmost bit of the word. When the first index is larger than the second, the run starts at the first index, passes the end of the word and continues from bit 0 up to the second index. Every bit outside the run is zero.

The block is meant to supply the mask for rotate-then-mask datapaths. The rotator feeds it the two boundary indices and ANDs the result with the rotated operand. The mask logic is purely combinational. A parameter `OUT_REG` adds a register stage after it. That stage costs one cycle of latency and has a valid flag aligned with the data. The stage is a two-state machine. In `OS_EMPTY` no valid mask is presented. In `OS_FULL` the mask captured on the last clock is presented with `mask_valid` high. Transition `T_LOAD` (any state to `OS_FULL`) fires on a clock with `in_valid` high. Transition `T_DRAIN` (any state to `OS_EMPTY`) fires on a clock with `in_valid` low, and the held mask stays unchanged. Reset forces `OS_EMPTY` with a zero mask.

Top module: `wrap_mask_gen`

## Requirements
- R1: Index 0 selects `mask_out[63]`, and index 63 selects `mask_out[0]`. Index i maps to port bit 63-i.
- R2: When `start_idx <= stop_idx`, the ones are exactly at indices `start_idx` through `stop_idx`, both ends included.
- R3: When `start_idx > stop_idx`, the ones are at indices `start_idx` through 63 and at indices 0 through `stop_idx`.
- R4: All other bits are zero, so the number of ones is `stop-start+1` in the first case and `65-start+stop` in the wrapped case.
- R5: When `start_idx == stop_idx`, exactly one bit of the mask is set.
- R6: When `start_idx` equals `stop_idx+1` modulo 64, the mask is all ones. Two examples are start 1 with stop 0, and start 0 with stop 63.
- R7: With `OUT_REG=1` (the default), the mask for the indices sampled on a clock edge appears after that edge, and `mask_valid` equals the `in_valid` sampled on the same edge.
- R8: After a clock edge with `in_valid` low, `mask_valid` is low and `mask_out` keeps its previous value.
- R9: While `rst_n` is low, `mask_out` is zero and `mask_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Indices are valid this cycle |
| start_idx | input | 6 | First index of the run (0 = MSB) |
| stop_idx | input | 6 | Last index of the run (0 = MSB) |
| mask_out | output | 64 | Generated mask |
| mask_valid | output | 1 | Mask on `mask_out` is valid |

## Verification
The bench sweeps all 4096 index pairs. This covers the equal-index case, where a design with an off-by-one boundary would set zero or two bits. It covers the adjacent pair that must give all ones, where a wrong choice between AND and OR would give all zeros or a single hole. It covers indices 0 and 63, where a shift by 64 or a reversed numbering would set the wrong end of the word. Idle cycles are inserted between requests so that a stage that reloads on invalid input, or lets the valid flag drift from the data, is caught. The count of ones is checked separately, which catches stray bits outside the run.

// File: rtl/mask_pkg.sv
package mask_pkg;

    // Output stage occupancy
    typedef enum logic {
        OS_EMPTY = 1'b0,
        OS_FULL  = 1'b1
    } ostate_t;

endpackage

// File: rtl/mrg_head_gen.sv
// Sets every bit whose MSB-first position is at or after the start index.
module mrg_head_gen #(
    parameter int W  = 64,
    parameter int IW = $clog2(W)
) (
    input  logic [IW-1:0] start_idx,
    output logic [W-1:0]  head
);
    for (genvar j = 0; j < W; j++) begin : g_bit
        localparam logic [IW:0] POS = (IW+1)'(W - 1 - j);
        assign head[j] = (POS >= {1'b0, start_idx});
    end
endmodule

// File: rtl/mrg_tail_gen.sv
// Sets every bit whose MSB-first position is at or before the stop index.
module mrg_tail_gen #(
    parameter int W  = 64,
    parameter int IW = $clog2(W)
) (
    input  logic [IW-1:0] stop_idx,
    output logic [W-1:0]  tail
);
    for (genvar j = 0; j < W; j++) begin : g_bit
        localparam logic [IW:0] POS = (IW+1)'(W - 1 - j);
        assign tail[j] = (POS <= {1'b0, stop_idx});
    end
endmodule

// File: rtl/mrg_combine.sv
// Intersects the two halves for a plain run, unites them for a wrapped run.
module mrg_combine #(
    parameter int W  = 64,
    parameter int IW = $clog2(W)
) (
    input  logic [IW-1:0] start_idx,
    input  logic [IW-1:0] stop_idx,
    input  logic [W-1:0]  head,
    input  logic [W-1:0]  tail,
    output logic [W-1:0]  mask
);
    logic wraps;

    always_comb begin
        wraps = (start_idx > stop_idx);
        if (wraps) begin
            mask = head | tail;
        end else begin
            mask = head & tail;
        end
    end
endmodule

// File: rtl/mrg_out_stage.sv
// Optional output register with a two-state occupancy machine.
module mrg_out_stage
    import mask_pkg::*;
#(
    parameter int W       = 64,
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] mask_in,
    output logic [W-1:0] mask_out,
    output logic         mask_valid
);
    if (OUT_REG) begin : g_reg
        ostate_t      state_q, state_d;
        logic [W-1:0] data_q;

        // next-state logic
        always_comb begin
            state_d = state_q;
            unique case (state_q)
                OS_EMPTY: state_d = in_valid ? OS_FULL : OS_EMPTY;  // T_LOAD
                OS_FULL:  state_d = in_valid ? OS_FULL : OS_EMPTY;  // T_DRAIN
                default:  state_d = OS_EMPTY;
            endcase
        end

        // state register
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_q <= OS_EMPTY;
            end else begin
                state_q <= state_d;
            end
        end

        // data register, loads only on T_LOAD
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q <= '0;
            end else if (in_valid) begin
                data_q <= mask_in;
            end
        end

        // outputs
        always_comb begin
            mask_out   = data_q;
            mask_valid = (state_q == OS_FULL);
        end
    end else begin : g_comb
        always_comb begin
            mask_out   = mask_in;
            mask_valid = in_valid;
        end
    end
endmodule

// File: rtl/wrap_mask_gen.sv
module wrap_mask_gen #(
    parameter int W       = 64,
    parameter bit OUT_REG = 1'b1,
    localparam int IW     = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [IW-1:0] start_idx,
    input  logic [IW-1:0] stop_idx,
    output logic [W-1:0]  mask_out,
    output logic          mask_valid
);
    logic [W-1:0] head;
    logic [W-1:0] tail;
    logic [W-1:0] mask_raw;

    mrg_head_gen #(.W(W), .IW(IW)) u_head (
        .start_idx (start_idx),
        .head      (head)
    );

    mrg_tail_gen #(.W(W), .IW(IW)) u_tail (
        .stop_idx (stop_idx),
        .tail     (tail)
    );

    mrg_combine #(.W(W), .IW(IW)) u_comb (
        .start_idx (start_idx),
        .stop_idx  (stop_idx),
        .head      (head),
        .tail      (tail),
        .mask      (mask_raw)
    );

    mrg_out_stage #(.W(W), .OUT_REG(OUT_REG)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .mask_in    (mask_raw),
        .mask_out   (mask_out),
        .mask_valid (mask_valid)
    );
endmodule

// File: rtl/wrap_mask_chk.sv
module wrap_mask_chk #(
    parameter int W       = 64,
    parameter bit OUT_REG = 1'b1,
    localparam int IW     = $clog2(W)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [IW-1:0] start_idx,
    input logic [IW-1:0] stop_idx,
    input logic [W-1:0]  mask_out,
    input logic          mask_valid
);
    if (OUT_REG) begin : g_seq
        logic [IW-1:0] s_q, e_q;
        always_ff @(posedge clk) begin
            s_q <= start_idx;
            e_q <= stop_idx;
        end

        p_single_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && start_idx == stop_idx) |=> ($countones(mask_out) == 1));

        p_full_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && start_idx == stop_idx + IW'(1)) |=> (&mask_out));

        p_start_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> mask_out[IW'(W-1) - s_q]);

        p_stop_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> mask_out[IW'(W-1) - e_q]);

        p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> mask_valid);

        p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!mask_valid && $stable(mask_out)));

        p_reset_clear_r9: assert property (@(posedge clk)
            !rst_n |=> (!$past(rst_n) -> (mask_out == '0 && !mask_valid)));
    end else begin : g_comb
        always_comb begin
            if (rst_n && in_valid && start_idx == stop_idx) begin
                a_single_bit_r5: assert ($countones(mask_out) == 1);
            end
            if (rst_n && in_valid && start_idx == stop_idx + IW'(1)) begin
                a_full_word_r6: assert (&mask_out);
            end
        end
    end
endmodule

bind wrap_mask_gen wrap_mask_chk #(.W(W), .OUT_REG(OUT_REG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .start_idx  (start_idx),
    .stop_idx   (stop_idx),
    .mask_out   (mask_out),
    .mask_valid (mask_valid)
);

// File: tb/sim_wrap_mask_gen.sv
`timescale 1ns/1ps
module sim_wrap_mask_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  s_i = '0;
    logic [5:0]  e_i = '0;
    logic [63:0] mask_out;
    logic        mask_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] exp_mask = '0;
    logic        exp_valid = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    wrap_mask_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .start_idx  (s_i),
        .stop_idx   (e_i),
        .mask_out   (mask_out),
        .mask_valid (mask_valid)
    );

    // Reference: index i is port bit 63-i
    function automatic logic [63:0] ref_mask(int s, int e);
        logic [63:0] r = '0;
        for (int i = 0; i < 64; i++) begin
            if (s <= e) r[63-i] = (i >= s && i <= e);
            else        r[63-i] = (i >= s || i <= e);
        end
        return r;
    endfunction

    function automatic int ref_count(int s, int e);
        return (s <= e) ? (e - s + 1) : (65 - s + e);
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(bit v, int s, int e);
        string tag;
        in_valid = v;
        s_i = 6'(s);
        e_i = 6'(e);
        @(posedge clk);
        exp_valid = v;
        if (v) exp_mask = ref_mask(s, e);
        @(negedge clk);
        chk("R7 valid", {63'd0, mask_valid}, {63'd0, exp_valid});
        if (v) begin
            if (s == e)                 tag = "R5 single";
            else if (s == ((e+1) % 64)) tag = "R6 full";
            else if (s > e)             tag = "R3 wrap";
            else                        tag = "R2 plain";
            chk(tag, mask_out, exp_mask);
            chk("R4 popcount", 64'($countones(mask_out)), 64'(ref_count(s, e)));
        end else begin
            chk("R8 hold", mask_out, exp_mask);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset mask", mask_out, 64'd0);
        chk("R9 reset valid", {63'd0, mask_valid}, 64'd0);
        rst_n = 1'b1;

        step(1'b1, 0, 0);
        chk("R1 index0", mask_out, 64'h8000_0000_0000_0000);
        step(1'b1, 63, 63);
        chk("R1 index63", mask_out, 64'h0000_0000_0000_0001);
        step(1'b1, 1, 0);
        chk("R6 start1 stop0", mask_out, '1);
        step(1'b1, 0, 63);
        chk("R6 start0 stop63", mask_out, '1);
        step(1'b1, 60, 3);
        chk("R3 wrap 60..3", mask_out, 64'hF000_0000_0000_000F);
        step(1'b0, 5, 9);
        step(1'b0, 2, 2);

        for (int s = 0; s < 64; s++) begin
            for (int e = 0; e < 64; e++) begin
                step(1'b1, s, e);
                if (((s * 64 + e) % 7) == 3) step(1'b0, e, s);
            end
        end

        for (int k = 0; k < 300; k++) begin
            step(($urandom % 4) != 0, int'($urandom % 64), int'($urandom % 64));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule